// File: doc/BRIEF.md
# Wormhole Router Input Port with Table Routing

This block is the receive side of one port of a five-port mesh or torus router. Flits arrive on a valid/ready link and wait in a first-in first-out buffer. When a packet's leading flit reaches the front of the buffer, its destination number picks an entry in a static routing table. The entry names the output direction. The port then claims that direction for the whole packet and keeps it until the last flit has gone. There are no virtual channels, so only one packet holds the port and its output path at a time.

The downstream crossbar stage sees two things. A path request with its direction stays up for the life of the packet. A separate flit-valid flag marks the cycles in which a flit is actually waiting. A flit leaves only when the crossbar grants the request and is ready to take it. Routing table entries are written through a simple synchronous write port.

Each flit is a 2-bit kind field above a 32-bit payload. The kind codes are: 00 single-flit packet, which both opens and closes a packet; 01 head; 10 body; 11 tail. A flit is present on a link only while its valid is high. The destination is the low bits of a leading flit's payload. Direction codes are 0 local, 1 north, 2 east, 3 south and 4 west.

Top module: `wh_input_port`

## Requirements
- R1: After reset, in_ready is 1, req_valid and out_valid are 0, and every table entry holds direction 0 (local).
- R2: A flit is stored when in_valid and in_ready are both high. Flits leave in arrival order. in_ready is 0 while DEPTH flits are held, and a flit offered then is not stored.
- R3: When a leading flit (kind 01 or 00) reaches the buffer front while the port is idle, req_valid rises one clock later. req_dir then equals the table entry indexed by the flit's low DEST_W payload bits, and that flit is on out_flit with out_valid high.
- R4: While a packet is open, req_valid stays high and req_dir is unchanged. This holds through cycles with no flit buffered (out_valid 0) and whatever the payload of body flits.
- R5: A flit is removed only in a cycle with out_valid, grant and out_ready all high. Otherwise out_flit and out_valid hold.
- R6: Removing a tail flit (kind 11) drops req_valid on the next cycle. The next packet's leading flit gets a new table lookup.
- R7: A single-flit packet (kind 00) raises one request that ends once that flit is removed.
- R8: A body or tail flit that reaches the buffer front while no packet is open is dropped without raising req_valid.
- R9: A table write with tbl_we high stores tbl_dir into entry tbl_idx on the clock edge when tbl_dir is 0 to 4. A write with a code of 5 to 7 leaves the entry unchanged.
- R10: A table write during an open packet does not change that packet's req_dir. Later packets use the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream flit present |
| in_flit | input | FLIT_W (34) | Upstream flit: kind [33:32], payload [31:0] |
| in_ready | output | 1 | Buffer has space |
| tbl_we | input | 1 | Routing table write enable |
| tbl_idx | input | DEST_W (4) | Table entry (destination number) to write |
| tbl_dir | input | 3 | Direction code to store |
| req_valid | output | 1 | Packet holds an output path |
| req_dir | output | 3 | Requested output direction |
| out_valid | output | 1 | A flit of the open packet is waiting |
| out_flit | output | FLIT_W (34) | Flit at the buffer front |
| grant | input | 1 | Crossbar grants this port's request |
| out_ready | input | 1 | Crossbar can accept the flit |

## Verification
The hardest states to reach are those where the path stays held but no flit is waiting, and where a table write lands in the middle of a packet. The bench reaches them by releasing the head flit before the body flit has been sent, so the buffer runs empty while the packet is open. It rewrites the destination's entry while the head is still stalled. A full-buffer test stalls the crossbar, fills all DEPTH slots, and offers one more flit. Draining the buffer and then sending a fresh packet shows that the extra flit was never stored.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
   typedef enum logic [1:0] {
      FK_SINGLE = 2'b00,
      FK_HEAD   = 2'b01,
      FK_BODY   = 2'b10,
      FK_TAIL   = 2'b11
   } flit_kind_e;

   localparam int DIR_W = 3;
   localparam logic [DIR_W-1:0] DIR_LOCAL = 3'd0;
   localparam logic [DIR_W-1:0] DIR_NORTH = 3'd1;
   localparam logic [DIR_W-1:0] DIR_EAST  = 3'd2;
   localparam logic [DIR_W-1:0] DIR_SOUTH = 3'd3;
   localparam logic [DIR_W-1:0] DIR_WEST  = 3'd4;
   localparam logic [DIR_W-1:0] DIR_MAX   = DIR_WEST;
endpackage

// File: rtl/wh_flit_fifo.sv
module wh_flit_fifo #(
   parameter int WIDTH = 34,
   parameter int DEPTH = 32,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic             full,
   output logic             empty,
   output logic [WIDTH-1:0] head_data
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("wh_flit_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign full      = (cnt == CNT_W'(DEPTH));
   assign empty     = (cnt == '0);
   assign head_data = mem[rd_ptr];
endmodule

// File: rtl/wh_route_table.sv
module wh_route_table
   import rtr_pkg::*;
#(
   parameter int NODES = 16,
   localparam int IDX_W = $clog2(NODES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DIR_W-1:0] wr_dir,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [DIR_W-1:0] rd_dir
);
   logic [DIR_W-1:0] ent [NODES];
   logic             dir_ok;

   assign dir_ok = (wr_dir <= DIR_MAX);

   generate
      for (genvar i = 0; i < NODES; i++) begin : g_ent
         always_ff @(posedge clk) begin
            if (!rst_n)
               ent[i] <= DIR_LOCAL;
            else if (wr_en && dir_ok && wr_idx == IDX_W'(i))
               ent[i] <= wr_dir;
         end
      end
   endgenerate

   always_comb begin
      rd_dir = DIR_LOCAL;
      if (int'(rd_idx) < NODES) rd_dir = ent[rd_idx];
   end
endmodule

// File: rtl/wh_route_ctrl.sv
module wh_route_ctrl
   import rtr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_empty,
   input  logic [1:0]       head_kind_raw,
   input  logic [DIR_W-1:0] lookup_dir,
   input  logic             grant,
   input  logic             out_ready,
   output logic             req_valid,
   output logic [DIR_W-1:0] req_dir,
   output logic             flit_valid,
   output logic             pop
);
   flit_kind_e       kind;
   logic             busy_q;
   logic [DIR_W-1:0] dir_q;
   logic             opens, closes, start, take, drop;

   always_comb begin
      kind   = flit_kind_e'(head_kind_raw);
      opens  = (kind == FK_HEAD) || (kind == FK_SINGLE);
      closes = (kind == FK_TAIL) || (kind == FK_SINGLE);
      start  = !busy_q && !fifo_empty && opens;
      drop   = !busy_q && !fifo_empty && !opens;
      take   = busy_q && !fifo_empty && grant && out_ready;
      pop    = take || drop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dir_q  <= DIR_LOCAL;
      end else if (start) begin
         busy_q <= 1'b1;
         dir_q  <= lookup_dir;
      end else if (take && closes) begin
         busy_q <= 1'b0;
      end
   end

   assign req_valid  = busy_q;
   assign req_dir    = dir_q;
   assign flit_valid = busy_q && !fifo_empty;
endmodule

// File: rtl/wh_input_port.sv
module wh_input_port
   import rtr_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32,
   parameter int NODES  = 16,
   localparam int FLIT_W = DATA_W + 2,
   localparam int DEST_W = $clog2(NODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [FLIT_W-1:0] in_flit,
   output logic              in_ready,
   input  logic              tbl_we,
   input  logic [DEST_W-1:0] tbl_idx,
   input  logic [DIR_W-1:0]  tbl_dir,
   output logic              req_valid,
   output logic [DIR_W-1:0]  req_dir,
   output logic              out_valid,
   output logic [FLIT_W-1:0] out_flit,
   input  logic              grant,
   input  logic              out_ready
);
   generate
      if (NODES < 2 || DEST_W > DATA_W) begin : g_bad_nodes
         $error("wh_input_port: NODES must be 2 or more and fit the payload");
      end
   endgenerate

   logic              full, empty, push, pop;
   logic [FLIT_W-1:0] head_data;
   logic [DIR_W-1:0]  lookup_dir;

   assign push     = in_valid && !full;
   assign in_ready = !full;

   wh_flit_fifo #(.WIDTH(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_flit),
      .pop(pop), .full(full), .empty(empty), .head_data(head_data)
   );

   wh_route_table #(.NODES(NODES)) u_table (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
      .wr_dir(tbl_dir), .rd_idx(head_data[DEST_W-1:0]), .rd_dir(lookup_dir)
   );

   wh_route_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .fifo_empty(empty),
      .head_kind_raw(head_data[FLIT_W-1 -: 2]), .lookup_dir(lookup_dir),
      .grant(grant), .out_ready(out_ready), .req_valid(req_valid),
      .req_dir(req_dir), .flit_valid(out_valid), .pop(pop)
   );

   assign out_flit = head_data;
endmodule

// File: rtl/wh_input_port_chk.sv
module wh_input_port_chk
   import rtr_pkg::*;
#(
   parameter int FLIT_W = 34
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [DIR_W-1:0]  req_dir,
   input logic              out_valid,
   input logic [FLIT_W-1:0] out_flit,
   input logic              grant,
   input logic              out_ready
);
   logic [1:0] kind;
   logic       moved, last;

   assign kind  = out_flit[FLIT_W-1 -: 2];
   assign moved = out_valid && grant && out_ready;
   assign last  = (kind == FK_TAIL) || (kind == FK_SINGLE);

   p_lead_on_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> out_valid && (kind == FK_HEAD || kind == FK_SINGLE));

   p_dir_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !(moved && last) |=> req_valid && $stable(req_dir));

   p_flit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !(grant && out_ready) |=> out_valid && $stable(out_flit));

   p_flit_needs_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> req_valid);

   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      moved && last |=> !req_valid);

   p_dir_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_dir <= DIR_MAX);
endmodule

bind wh_input_port wh_input_port_chk #(.FLIT_W(FLIT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
   .out_valid(out_valid), .out_flit(out_flit), .grant(grant),
   .out_ready(out_ready)
);

// File: tb/wh_input_port_test.sv
module wh_input_port_test;
   localparam int DATA_W = 32;
   localparam int DEPTH  = 32;
   localparam int NODES  = 16;
   localparam int FW     = DATA_W + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [FW-1:0] in_flit = '0;
   logic          in_ready;
   logic          tbl_we = 1'b0;
   logic [3:0]    tbl_idx = '0;
   logic [2:0]    tbl_dir = '0;
   logic          req_valid;
   logic [2:0]    req_dir;
   logic          out_valid;
   logic [FW-1:0] out_flit;
   logic          grant = 1'b0;
   logic          out_ready = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   wh_input_port #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NODES(NODES)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
      .in_ready(in_ready), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
      .tbl_dir(tbl_dir), .req_valid(req_valid), .req_dir(req_dir),
      .out_valid(out_valid), .out_flit(out_flit), .grant(grant),
      .out_ready(out_ready)
   );

   function automatic logic [FW-1:0] mk(input logic [1:0] k, input logic [31:0] p);
      return {k, p};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic push(input logic [FW-1:0] f);
      in_valid = 1'b1;
      in_flit  = f;
      tick();
      in_valid = 1'b0;
   endtask

   task automatic take(input logic [FW-1:0] exp, input string req);
      check(out_valid == 1'b1, req, "out_valid before removal", 64'(out_valid), 64'd1);
      check(out_flit == exp, req, "out_flit order", 64'(out_flit), 64'(exp));
      grant = 1'b1;
      out_ready = 1'b1;
      tick();
      grant = 1'b0;
      out_ready = 1'b0;
   endtask

   task automatic twrite(input logic [3:0] idx, input logic [2:0] d);
      tbl_we  = 1'b1;
      tbl_idx = idx;
      tbl_dir = d;
      tick();
      tbl_we  = 1'b0;
   endtask

   task automatic t_reset();
      check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
      check(req_valid == 1'b0, "R1", "req_valid after reset", 64'(req_valid), 64'd0);
      check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      // R1: untouched entry 9 routes local
      push(mk(2'b00, 32'd9));
      tick();
      check(req_valid && req_dir == 3'd0, "R1", "default entry local", 64'(req_dir), 64'd0);
      take(mk(2'b00, 32'd9), "R1");
   endtask

   task automatic t_table();
      twrite(4'd3, 3'd2);
      twrite(4'd5, 3'd4);
      twrite(4'd7, 3'd1);
      twrite(4'd3, 3'd7); // R9: illegal code, must be ignored
   endtask

   task automatic t_wormhole();
      logic [FW-1:0] hd;
      hd = mk(2'b01, 32'hAB00_0003);
      push(hd);
      tick();
      check(req_valid == 1'b1, "R3", "req after head", 64'(req_valid), 64'd1);
      check(req_dir == 3'd2, "R9", "dest 3 east, illegal write ignored", 64'(req_dir), 64'd2);
      check(out_flit == hd, "R3", "head on out_flit", 64'(out_flit), 64'(hd));
      tick(); tick();
      check(out_valid && out_flit == hd, "R5", "hold without grant", 64'(out_flit), 64'(hd));
      grant = 1'b1;
      tick();
      grant = 1'b0;
      check(out_valid && out_flit == hd, "R5", "hold with grant but not ready", 64'(out_flit), 64'(hd));
      twrite(4'd3, 3'd3); // R10: rewrite mid packet
      check(req_dir == 3'd2, "R10", "dir held across table write", 64'(req_dir), 64'd2);
      take(hd, "R3");
      check(req_valid && !out_valid, "R4", "path held while buffer empty",
            64'({req_valid, out_valid}), 64'b10);
      check(req_dir == 3'd2, "R4", "dir held while empty", 64'(req_dir), 64'd2);
      push(mk(2'b10, 32'd5));
      check(req_dir == 3'd2, "R4", "body payload ignored", 64'(req_dir), 64'd2);
      take(mk(2'b10, 32'd5), "R4");
      push(mk(2'b11, 32'd1));
      take(mk(2'b11, 32'd1), "R6");
      check(req_valid == 1'b0, "R6", "release after tail", 64'(req_valid), 64'd0);
      push(mk(2'b01, 32'd3));
      tick();
      check(req_valid && req_dir == 3'd3, "R10", "next packet uses new entry", 64'(req_dir), 64'd3);
      push(mk(2'b11, 32'd2));
      take(mk(2'b01, 32'd3), "R6");
      take(mk(2'b11, 32'd2), "R6");
   endtask

   task automatic t_single();
      push(mk(2'b00, 32'd7));
      tick();
      check(req_valid && req_dir == 3'd1, "R7", "single routes north", 64'(req_dir), 64'd1);
      take(mk(2'b00, 32'd7), "R7");
      check(req_valid == 1'b0, "R7", "single releases", 64'(req_valid), 64'd0);
      push(mk(2'b00, 32'd5));
      push(mk(2'b00, 32'd3));
      check(req_valid && req_dir == 3'd4, "R7", "first single west", 64'(req_dir), 64'd4);
      take(mk(2'b00, 32'd5), "R7");
      check(req_valid == 1'b0, "R6", "gap between packets", 64'(req_valid), 64'd0);
      tick();
      check(req_valid && req_dir == 3'd3, "R6", "fresh lookup second single", 64'(req_dir), 64'd3);
      take(mk(2'b00, 32'd3), "R7");
   endtask

   task automatic t_orphan();
      push(mk(2'b10, 32'd7));
      tick(); tick();
      check(!req_valid && !out_valid, "R8", "orphan body raises nothing",
            64'({req_valid, out_valid}), 64'd0);
      push(mk(2'b11, 32'd5));
      tick(); tick();
      check(!req_valid && !out_valid, "R8", "orphan tail raises nothing",
            64'({req_valid, out_valid}), 64'd0);
      push(mk(2'b01, 32'd7));
      tick();
      check(req_valid && req_dir == 3'd1, "R8", "head after orphans", 64'(req_dir), 64'd1);
      push(mk(2'b11, 32'd0));
      take(mk(2'b01, 32'd7), "R8");
      take(mk(2'b11, 32'd0), "R8");
   endtask

   task automatic t_full();
      push(mk(2'b01, 32'd5));
      for (int i = 1; i < DEPTH - 1; i++) push(mk(2'b10, 32'(i)));
      push(mk(2'b11, 32'(DEPTH - 1)));
      check(in_ready == 1'b0, "R2", "in_ready low when full", 64'(in_ready), 64'd0);
      in_valid = 1'b1;
      in_flit  = mk(2'b10, 32'hDEAD);
      tick();
      in_valid = 1'b0;
      check(in_ready == 1'b0, "R2", "still full after refused flit", 64'(in_ready), 64'd0);
      take(mk(2'b01, 32'd5), "R2");
      check(in_ready == 1'b1, "R2", "space after one removal", 64'(in_ready), 64'd1);
      for (int i = 1; i < DEPTH - 1; i++) take(mk(2'b10, 32'(i)), "R2");
      take(mk(2'b11, 32'(DEPTH - 1)), "R2");
      check(!req_valid && !out_valid, "R2", "drained", 64'({req_valid, out_valid}), 64'd0);
      push(mk(2'b00, 32'd7));
      tick();
      check(out_flit == mk(2'b00, 32'd7), "R2", "refused flit not stored",
            64'(out_flit), 64'(mk(2'b00, 32'd7)));
      take(mk(2'b00, 32'd7), "R2");
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_table();
      t_wormhole();
      t_single();
      t_orphan();
      t_full();
      repeat (2) tick();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule